// File: doc/BRIEF.md
# Single-Wire Trigger and Timestamp Receiver

This block watches one serial line that carries both a trigger instant and the time tag belonging to it. A rising edge on the idle line marks the trigger moment. The line then stays high for a fixed pulse and low for a fixed gap. After that, a 24-bit timestamp follows in fixed-width bit slots, most significant bit first. All timing is counted in cycles of the receiving clock. The defaults assume 80 MHz: a 16-cycle pulse, a 24-cycle gap and 8 cycles per bit, so a frame lasts 232 cycles.

The receiver issues a one-cycle trigger strobe at a fixed latency after the edge. It then checks the length of the high pulse, samples each data bit at the centre of its slot and presents the full timestamp together with a one-cycle valid strobe. A frame whose high pulse is too short or too long is aborted with a one-cycle error strobe. Once a trigger has been accepted, later rising edges are ignored for a hold-off window as long as one acquisition event (512 cycles by default). Data bits therefore never pass as new triggers.

Top module: `tsr_trig_stamp_rx`

## Requirements
- R1: While reset is held and right after it, `trig_o`, `ts_valid_o` and `frame_err_o` are 0 and `ts_o` is all zeros.
- R2: When the line is first sampled high after being sampled low at the previous clock edge, and the receiver is accepting, `trig_o` is high for exactly one cycle. That cycle begins at the next clock edge after the first high sample.
- R3: Let the trigger-strobe cycle be frame cycle 0. The high pulse length is the number of consecutive cycles, counted from cycle 0, in which the synchronized line is high. A length from 14 to 18 inclusive is accepted. A length of 13 or less raises `frame_err_o` for one cycle right after the first low cycle. A length of 19 or more raises it for one cycle right after frame cycle 18. Either error ends the frame.
- R4: Timestamp bit k (k = 0 is the most significant) is sampled from the synchronized line in frame cycle 44 + 8k, the centre of the slot that starts at cycle 40 + 8k. It ends up at bit position 23 − k of `ts_o`.
- R5: For an accepted frame, `ts_valid_o` is high for one cycle, in frame cycle 232. `ts_o` takes the new value in that same cycle and keeps it until the next valid strobe.
- R6: No trigger strobe is produced for any rising edge whose strobe cycle would fall within 512 cycles of the last accepted strobe. This covers edges between data bits, edges after the frame and edges after an aborted frame.
- R7: A rising edge whose strobe cycle is 512 or more cycles after the previous accepted strobe is accepted as a new trigger.
- R8: An aborted frame produces no `ts_valid_o` and leaves `ts_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Asynchronous serial trigger and timestamp line |
| trig_o | output | 1 | One-cycle trigger strobe |
| ts_o | output | 24 | Last timestamp received |
| ts_valid_o | output | 1 | One-cycle strobe: `ts_o` holds a new timestamp |
| frame_err_o | output | 1 | One-cycle strobe: high pulse out of tolerance, frame aborted |

## Verification
Frames are sent with an irregular timestamp, with all zeros, with all ones and with alternating ones and zeros. The all-zeros and all-ones frames show whether bits land in the right positions and in MSB-first order. The alternating pattern also puts a rising edge into every other bit slot, so any leak of data bits into the trigger path shows up. High pulses of 13, 14, 18 and 19 cycles sit on either side of the tolerance bounds. Extra pulses inside the hold-off window, both after a good frame and after an aborted one, separate blanking from frame decoding. The next frame, sent just after the window closes, shows that triggers are accepted again.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } tsr_state_e;

endpackage

// File: rtl/tsr_rst_sync.sv
module tsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_nxt;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] stg_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d_in;
    if (g == 0) begin : g_first
      assign d_in = line_i;
    end else begin : g_next
      assign d_in = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= 1'b0;
      else        stg_q[g] <= d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tsr_frame_ctl.sv
module tsr_frame_ctl
  import tsr_pkg::*;
#(
  parameter int TS_W     = 24,
  parameter int HIGH_CYC = 16,
  parameter int GAP_CYC  = 24,
  parameter int BIT_CYC  = 8,
  parameter int HIGH_TOL = 2,
  parameter int HOLD_CYC = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  output logic trig_o,
  output logic smp_o,
  output logic done_o,
  output logic err_o
);

  localparam int FC_W  = $clog2(HIGH_CYC + GAP_CYC + 1);
  localparam int PH_W  = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int IDX_W = (TS_W > 1) ? $clog2(TS_W) : 1;
  localparam int HC_W  = $clog2(HOLD_CYC + 1);

  localparam logic [FC_W-1:0]  FC_HI_MIN = FC_W'(HIGH_CYC - HIGH_TOL);
  localparam logic [FC_W-1:0]  FC_HI_MAX = FC_W'(HIGH_CYC + HIGH_TOL);
  localparam logic [FC_W-1:0]  FC_GAPEND = FC_W'(HIGH_CYC + GAP_CYC - 1);
  localparam logic [PH_W-1:0]  PH_MID    = PH_W'(BIT_CYC / 2);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(BIT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(TS_W - 1);
  localparam logic [HC_W-1:0]  HC_LOAD   = HC_W'(HOLD_CYC - 1);

  tsr_state_e       st_q, st_nxt;
  logic [FC_W-1:0]  fc_q, fc_nxt;
  logic [PH_W-1:0]  ph_q, ph_nxt;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [HC_W-1:0]  hc_q, hc_nxt;
  logic             err_q, err_nxt;
  logic             accept;
  logic             done_c;
  logic             smp_c;

  assign accept = rise_i && (st_q == ST_IDLE) && (hc_q == '0);

  always_comb begin
    st_nxt  = st_q;
    fc_nxt  = fc_q;
    ph_nxt  = ph_q;
    idx_nxt = idx_q;
    err_nxt = 1'b0;
    done_c  = 1'b0;
    smp_c   = 1'b0;

    if (accept)            hc_nxt = HC_LOAD;
    else if (hc_q != '0)   hc_nxt = hc_q - 1'b1;
    else                   hc_nxt = hc_q;

    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_nxt = ST_HIGH;
          fc_nxt = FC_W'(1);
        end
      end
      ST_HIGH: begin
        if (lvl_i) begin
          if (fc_q == FC_HI_MAX) begin
            err_nxt = 1'b1;
            st_nxt  = ST_IDLE;
          end else begin
            fc_nxt = fc_q + 1'b1;
          end
        end else begin
          if (fc_q < FC_HI_MIN) begin
            err_nxt = 1'b1;
            st_nxt  = ST_IDLE;
          end else begin
            st_nxt = ST_GAP;
            fc_nxt = fc_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (fc_q == FC_GAPEND) begin
          st_nxt  = ST_DATA;
          ph_nxt  = '0;
          idx_nxt = '0;
        end else begin
          fc_nxt = fc_q + 1'b1;
        end
      end
      ST_DATA: begin
        smp_c = (ph_q == PH_MID);
        if (ph_q == PH_LAST) begin
          ph_nxt = '0;
          if (idx_q == IDX_LAST) begin
            done_c = 1'b1;
            st_nxt = ST_IDLE;
          end else begin
            idx_nxt = idx_q + 1'b1;
          end
        end else begin
          ph_nxt = ph_q + 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      fc_q  <= '0;
      ph_q  <= '0;
      idx_q <= '0;
      hc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      fc_q  <= fc_nxt;
      ph_q  <= ph_nxt;
      idx_q <= idx_nxt;
      hc_q  <= hc_nxt;
      err_q <= err_nxt;
    end
  end

  assign trig_o = accept;
  assign smp_o  = smp_c;
  assign done_o = done_c;
  assign err_o  = err_q;

  // R2
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R6
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> (hc_q != '0));

  // R3
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (st_q == ST_IDLE));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_c |=> !done_c);

endmodule

// File: rtl/tsr_shift_out.sv
module tsr_shift_out #(
  parameter int TS_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lvl_i,
  input  logic            smp_i,
  input  logic            done_i,
  output logic [TS_W-1:0] ts_o,
  output logic            valid_o
);

  logic [TS_W-1:0] sr_q, sr_nxt;
  logic [TS_W-1:0] ts_q, ts_nxt;
  logic            val_q;

  always_comb begin
    sr_nxt = sr_q;
    if (smp_i) sr_nxt = {sr_q[TS_W-2:0], lvl_i};
    ts_nxt = ts_q;
    if (done_i) ts_nxt = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      ts_q  <= '0;
      val_q <= 1'b0;
    end else begin
      sr_q  <= sr_nxt;
      ts_q  <= ts_nxt;
      val_q <= done_i;
    end
  end

  assign ts_o    = ts_q;
  assign valid_o = val_q;

  // R5
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(ts_q));

endmodule

// File: rtl/tsr_trig_stamp_rx.sv
module tsr_trig_stamp_rx #(
  parameter int TS_W      = 24,
  parameter int HIGH_CYC  = 16,
  parameter int GAP_CYC   = 24,
  parameter int BIT_CYC   = 8,
  parameter int HIGH_TOL  = 2,
  parameter int HOLD_CYC  = 512,
  parameter int SYNC_STG  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_i,
  output logic            trig_o,
  output logic [TS_W-1:0] ts_o,
  output logic            ts_valid_o,
  output logic            frame_err_o
);

  logic rst_n_s;
  logic lvl;
  logic rise;
  logic smp;
  logic done;

  tsr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  tsr_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .line_i (line_i),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  tsr_frame_ctl #(
    .TS_W     (TS_W),
    .HIGH_CYC (HIGH_CYC),
    .GAP_CYC  (GAP_CYC),
    .BIT_CYC  (BIT_CYC),
    .HIGH_TOL (HIGH_TOL),
    .HOLD_CYC (HOLD_CYC)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .lvl_i  (lvl),
    .rise_i (rise),
    .trig_o (trig_o),
    .smp_o  (smp),
    .done_o (done),
    .err_o  (frame_err_o)
  );

  tsr_shift_out #(.TS_W(TS_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .lvl_i   (lvl),
    .smp_i   (smp),
    .done_i  (done),
    .ts_o    (ts_o),
    .valid_o (ts_valid_o)
  );

  // R8
  err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_err_o |-> !ts_valid_o);

endmodule

// File: tb/sim_tsr_trig_stamp_rx.sv
`timescale 1ns/1ps
module sim_tsr_trig_stamp_rx;

  localparam int HOLD = 512;

  logic        clk;
  logic        rst_n;
  logic        line_i;
  logic        trig_o;
  logic [23:0] ts_o;
  logic        ts_valid_o;
  logic        frame_err_o;

  int checks;
  int errors;
  bit run;
  bit finished;

  tsr_trig_stamp_rx u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_i      (line_i),
    .trig_o      (trig_o),
    .ts_o        (ts_o),
    .ts_valid_o  (ts_valid_o),
    .frame_err_o (frame_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // line history sampled at every rising edge
  bit hist[$];
  always @(posedge clk) begin
    hist.push_back(line_i);
    if (hist.size() > 6) void'(hist.pop_front());
  end

  // behavioural reference model, compared every cycle
  int          m_t;
  bit          m_hi;
  int          m_hold;
  logic [23:0] m_bits;
  bit          e_valid;
  bit          e_err;
  logic [23:0] e_ts;
  int          n_trig;
  int          n_valid;
  int          n_err;

  always @(negedge clk) begin
    if (run) begin
      bit v;
      bit pv;
      bit acc;
      bit nv;
      bit ne;
      v   = hist[hist.size()-2];
      pv  = hist[hist.size()-3];
      acc = (m_t < 0) && (m_hold == 0) && v && !pv;
      chk(trig_o == acc, "R2/R6 trig", trig_o, acc);
      chk(ts_valid_o == e_valid, "R5 valid", ts_valid_o, e_valid);
      chk(frame_err_o == e_err, "R3 err", frame_err_o, e_err);
      chk(ts_o == e_ts, "R4 ts", ts_o, e_ts);
      if (trig_o) n_trig++;
      if (ts_valid_o) n_valid++;
      if (frame_err_o) n_err++;
      nv = 1'b0;
      ne = 1'b0;
      if (m_hold > 0) m_hold--;
      if (acc) begin
        m_t = 1; m_hi = 1'b1; m_hold = HOLD - 1;
      end else if (m_t >= 0) begin
        if (m_hi) begin
          if (!v) begin
            if (m_t < 14) begin ne = 1'b1; m_t = -1; end
            else begin m_hi = 1'b0; m_t++; end
          end else if (m_t == 18) begin
            ne = 1'b1; m_t = -1;
          end else m_t++;
        end else begin
          if (m_t >= 40 && ((m_t - 40) % 8) == 4) m_bits = {m_bits[22:0], v};
          if (m_t == 231) begin nv = 1'b1; e_ts = m_bits; m_t = -1; end
          else m_t++;
        end
      end
      e_valid = nv;
      e_err   = ne;
    end
  end

  // one frame plus idle time, optional extra pulse at offset pulse_at
  task automatic frame(input int hi, input logic [23:0] ts, input int pulse_at, input string tag);
    int t0, v0, e0;
    logic [23:0] ts_before;
    bit ok;
    t0 = n_trig; v0 = n_valid; e0 = n_err;
    ts_before = ts_o;
    ok = (hi >= 14) && (hi <= 18);
    for (int c = 0; c < 560; c++) begin
      @(negedge clk);
      if (c == 1) chk(trig_o == 1'b0, "R2 latency early", trig_o, 0);
      if (c == 2) chk(trig_o == 1'b1, "R2 latency", trig_o, 1);
      if (c < hi)                    line_i = 1'b1;
      else if (c < 40)               line_i = 1'b0;
      else if (c < 232)              line_i = ts[23 - (c - 40) / 8];
      else if (pulse_at > 0 && c >= pulse_at && c < pulse_at + 3) line_i = 1'b1;
      else                           line_i = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(n_trig - t0 == 1, {tag, " R6 one trigger per frame"}, n_trig - t0, 1);
    chk(n_valid - v0 == (ok ? 1 : 0), {tag, " R5 valid count"}, n_valid - v0, ok ? 1 : 0);
    chk(n_err - e0 == (ok ? 0 : 1), {tag, " R3 error count"}, n_err - e0, ok ? 0 : 1);
    if (ok) chk(ts_o == ts, {tag, " R4 timestamp"}, ts_o, ts);
    else    chk(ts_o == ts_before, {tag, " R8 timestamp kept"}, ts_o, ts_before);
  endtask

  initial begin
    checks = 0; errors = 0; run = 1'b0; finished = 1'b0;
    m_t = -1; m_hi = 1'b0; m_hold = 0; m_bits = '0;
    e_valid = 1'b0; e_err = 1'b0; e_ts = '0;
    n_trig = 0; n_valid = 0; n_err = 0;
    for (int i = 0; i < 6; i++) hist.push_back(1'b0);
    line_i = 1'b0;
    rst_n  = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(trig_o == 1'b0, "R1 trig", trig_o, 0);
    chk(ts_valid_o == 1'b0, "R1 valid", ts_valid_o, 0);
    chk(frame_err_o == 1'b0, "R1 err", frame_err_o, 0);
    chk(ts_o == 24'h0, "R1 ts", ts_o, 0);
    rst_n = 1'b1;
    run   = 1'b1;
    repeat (8) @(negedge clk);
    chk(ts_o == 24'h0, "R1 ts after release", ts_o, 0);

    frame(16, 24'hA5C3F1, 300, "nominal");
    frame(16, 24'h000000, 0,   "zeros");
    frame(16, 24'hFFFFFF, 0,   "ones");
    frame(16, 24'h555555, 400, "alternating R6");
    frame(14, 24'h12345E, 0,   "short edge ok");
    frame(18, 24'h8000C1, 0,   "long edge ok");
    frame(13, 24'h3C3C3C, 100, "too short");
    frame(19, 24'hC3C3C3, 300, "too long");
    frame(16, 24'h7E1D04, 0,   "R7 rearm");
    repeat (10) @(negedge clk);
    finish_run();
  end

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule